// File: doc/BRIEF.md
# Switched-Reference Digital Clock Recovery Loop

This block regenerates receive timing with a fully digital phase-locked loop that runs on the system clock. A phase accumulator acts as the oscillator. Its top bits form a divide-by-four chain, and that chain produces single-cycle enables at four times, twice and once the bit rate. Once per bit period, a phase detector samples the chain against a reference event. A proportional-integral filter then corrects the accumulator increment.

The reference source follows carrier detect. With carrier present, the reference is the rising edges of the extracted receive reference. Without carrier, it is every fourth tick of a local oscillator running at the 4X rate. The loop therefore keeps supplying clock enables and stays at the right frequency while the line is idle, so a new frame only needs a phase correction. When carrier detect rises, the block raises a silence flag. Data recovery uses this flag to discard bits while the loop pulls in.

Top module: `clk_recovery_dpll`

## Requirements
- R1: With `cd` low, the reference event is every fourth `osc_tick` pulse, and `rx_ref` has no effect on any output. With `cd` high, the reference event is each low-to-high transition of `rx_ref`.
- R2: On every clock, the 14-bit phase accumulator advances by an increment. The increment is `NOM_INC` plus the integral term plus the proportional term, clamped to the range 1..4095. `ce4x` pulses for one cycle, one clock after the low 12 bits wrap.
- R3: `ce2x` pulses one clock after the low 13 bits wrap, and `ce1x` pulses one clock after the full 14 bits wrap. As a result, `ce1x` implies `ce2x`, `ce2x` implies `ce4x`, and the three run at a 1:2:4 ratio.
- R4: The filter updates only on a reference event. The error is the negated accumulator value read as two's complement. The integral term gains the error shifted right arithmetically by `KI`, and the proportional term becomes the error shifted right by `KP`.
- R5: A change of `cd` leaves the filter state untouched. The `ce1x` rate therefore stays continuous across the hand-off in either direction, and the loop relocks on the local reference after a frame.
- R6: A reference event whose error lies outside ±`LOCK_WIN` clears `lock` from the next clock. `lock` is high once `LOCK_CNT` consecutive events have fallen inside the window.
- R7: When carrier starts with a training reference at the nominal rate and an arbitrary phase, `lock` returns within 24 bit times.
- R8: With `cd` low and `osc_tick` at the nominal 4X rate, the enables keep running at the nominal rate and `lock` asserts.
- R9: A rising edge of `cd` sets `silence` on the next clock. `silence` stays high through 18 `ce1x` pulses, which is 17 to 18 bit times, and clears on the clock after the last of them.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | Local oscillator pulse at the 4X rate |
| cd | input | 1 | Carrier detect |
| rx_ref | input | 1 | Receive-derived reference level, one period per bit |
| ce4x | output | 1 | Enable pulse at four times the bit rate |
| ce2x | output | 1 | Enable pulse at twice the bit rate |
| ce1x | output | 1 | Enable pulse at the bit rate |
| lock | output | 1 | Phase error has stayed inside the window |
| silence | output | 1 | Receive data to be forced silent |

## Verification
The assertions assume that `cd` and `rx_ref` are synchronous to `clk` and held stable between edges. They also assume that `rx_ref` has no more than one rising edge per bit period, so the filter sees at most one event per loop cycle. The stimulus changes every input only on the falling clock edge. The local tick runs every 10 clocks, and the receive reference is a 40-clock square wave shifted by a third of a bit, so both sources meet these conditions while still forcing a large phase step at each hand-off.

// File: rtl/clk_recovery_dpll.sv
`timescale 1ns/1ps
module clk_recovery_dpll #(
  parameter int ACC_W    = 12,
  parameter int NOM_INC  = 410,
  parameter int KP       = 6,
  parameter int KI       = 7,
  parameter int IW       = 20,
  parameter int LOCK_WIN = 256,
  parameter int LOCK_CNT = 4,
  parameter int SIL_LEN  = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic cd,
  input  logic rx_ref,
  output logic ce4x,
  output logic ce2x,
  output logic ce1x,
  output logic lock,
  output logic silence
);
  localparam int PW   = ACC_W + 2;
  localparam int CW   = $clog2(LOCK_CNT + 1);
  localparam int SW   = $clog2(SIL_LEN + 1);
  localparam int MAXI = 2**ACC_W - 1;

  logic                 rx_d, cd_d, c4, c2, c1;
  logic [1:0]           lo_cnt;
  logic [PW-1:0]        ph;
  logic signed [IW-1:0] integ, prop;
  logic [CW-1:0]        lk_cnt;
  logic [SW-1:0]        sil_cnt;

  wire rx_rise = rx_ref & ~rx_d;
  wire lo_ev   = osc_tick & (lo_cnt == 2'd3);
  wire ref_ev  = cd ? rx_rise : lo_ev;
  wire cd_rise = cd & ~cd_d;

  logic signed [PW:0]   err;
  logic signed [IW-1:0] ew;
  logic signed [IW+1:0] raw;
  logic [ACC_W-1:0]     inc;
  logic                 in_win;

  assign err    = -((PW+1)'($signed(ph)));
  assign ew     = IW'(err);
  assign in_win = (err <= (PW+1)'(LOCK_WIN)) && (err >= -((PW+1)'(LOCK_WIN)));
  assign raw    = (IW+2)'(NOM_INC) + (IW+2)'(integ) + (IW+2)'(prop);
  assign inc    = (raw < (IW+2)'(1))    ? ACC_W'(1) :
                  (raw > (IW+2)'(MAXI)) ? ACC_W'(MAXI) : raw[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_d    <= 1'b0;
      cd_d    <= 1'b0;
      lo_cnt  <= '0;
      ph      <= '0;
      c4      <= 1'b0;
      c2      <= 1'b0;
      c1      <= 1'b0;
      integ   <= '0;
      prop    <= '0;
      lk_cnt  <= '0;
      sil_cnt <= '0;
    end else begin
      rx_d <= rx_ref;
      cd_d <= cd;
      if (osc_tick) lo_cnt <= lo_cnt + 2'd1;
      c4 <= ph[ACC_W-1:0] > ~inc;
      c2 <= ph[ACC_W:0]   > ~{1'b0, inc};
      c1 <= ph            > ~{2'b0, inc};
      ph <= ph + {2'b0, inc};
      if (ref_ev) begin
        integ  <= integ + (ew >>> KI);
        prop   <= ew >>> KP;
        lk_cnt <= !in_win ? '0 : (lk_cnt == CW'(LOCK_CNT)) ? lk_cnt : lk_cnt + 1'b1;
      end
      if (cd_rise)                sil_cnt <= SW'(SIL_LEN);
      else if (c1 && sil_cnt != 0) sil_cnt <= sil_cnt - 1'b1;
    end
  end

  assign ce4x    = c4;
  assign ce2x    = c2;
  assign ce1x    = c1;
  assign lock    = (lk_cnt == CW'(LOCK_CNT));
  assign silence = (sil_cnt != 0);

  // R3
  one_implies_two_chk: assert property (@(posedge clk) disable iff (!rst_n) ce1x |-> ce2x);
  // R3
  two_implies_four_chk: assert property (@(posedge clk) disable iff (!rst_n) ce2x |-> ce4x);
  // R4
  filter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !ref_ev |=> $stable(integ) && $stable(prop));
  // R6
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (ref_ev && !in_win) |=> !lock);
  // R9
  silence_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cd) |=> silence);
  // R9
  silence_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(silence) |-> $past(ce1x));
endmodule

// File: tb/sim_clk_recovery_dpll.sv
`timescale 1ns/1ps
module sim_clk_recovery_dpll;
  logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, cd = 1'b0, rx_ref = 1'b0;
  logic ce4x, ce2x, ce1x, lock, silence;
  int nchk = 0, nerr = 0, cyc = 0;
  localparam int RX_OFF = 13;

  always #2.5 clk = ~clk;

  clk_recovery_dpll u0 (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cd(cd), .rx_ref(rx_ref),
                        .ce4x(ce4x), .ce2x(ce2x), .ce1x(ce1x), .lock(lock), .silence(silence));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph, m_int, m_prop, m_lk, m_sil, m_lo;
  bit m_c4, m_c2, m_c1, m_rxd, m_cdd;
  always @(posedge clk or negedge rst_n) begin : model
    int inc, sp, er, nint, nprop, nlk, nsil;
    bit ev;
    if (!rst_n) begin
      m_ph = 0; m_int = 0; m_prop = 0; m_lk = 0; m_sil = 0; m_lo = 0;
      m_c4 = 0; m_c2 = 0; m_c1 = 0; m_rxd = 0; m_cdd = 0;
    end else begin
      inc = 410 + m_int + m_prop;
      if (inc < 1) inc = 1;
      if (inc > 4095) inc = 4095;
      ev = cd ? (rx_ref && !m_rxd) : (osc_tick && m_lo == 3);
      sp = (m_ph >= 8192) ? m_ph - 16384 : m_ph;
      er = -sp;
      nint = m_int; nprop = m_prop; nlk = m_lk;
      if (ev) begin
        nint  = m_int + (er >>> 7);
        nprop = er >>> 6;
        nlk   = (er <= 256 && er >= -256) ? ((m_lk < 4) ? m_lk + 1 : 4) : 0;
      end
      nsil = m_sil;
      if (cd && !m_cdd) nsil = 18;
      else if (m_c1 && m_sil > 0) nsil = m_sil - 1;
      m_c4 = ((m_ph % 4096) + inc) >= 4096;
      m_c2 = ((m_ph % 8192) + inc) >= 8192;
      m_c1 = (m_ph + inc) >= 16384;
      m_ph = (m_ph + inc) % 16384;
      m_int = nint; m_prop = nprop; m_lk = nlk; m_sil = nsil;
      m_rxd = rx_ref; m_cdd = cd;
      if (osc_tick) m_lo = (m_lo + 1) % 4;
    end
  end

  // per-cycle comparison, then stimulus generators
  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] act, exp;
      act = {ce4x, ce2x, ce1x, lock, silence};
      exp = {m_c4, m_c2, m_c1, (m_lk == 4), (m_sil != 0)};
      chk(act == exp, "R2 R4 R6 R9 model compare", int'(act), int'(exp));
    end
    cyc++;
    osc_tick = (cyc % 10 == 0);
    rx_ref   = ((cyc + RX_OFF) % 40) < 20;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    int n1, n2, n4, fell_at, relock_at, sil_p;
    bit held;
    repeat (5) @(negedge clk);
    // R10
    chk({ce4x, ce2x, ce1x, lock, silence} == 5'b0, "R10 reset outputs",
        int'({ce4x, ce2x, ce1x, lock, silence}), 0);
    rst_n = 1'b1;
    repeat (2400) @(negedge clk);
    // R8
    chk(lock == 1'b1, "R8 lock on local reference", int'(lock), 1);
    n1 = 0; n2 = 0; n4 = 0; held = 1;
    repeat (400) begin
      @(negedge clk);
      n1 += int'(ce1x); n2 += int'(ce2x); n4 += int'(ce4x);
      if (!lock) held = 0;
    end
    chk(n1 >= 9 && n1 <= 11, "R8 idle ce1x rate", n1, 10);
    // R3
    chk(n2 >= 2*n1 - 2 && n2 <= 2*n1 + 2, "R3 ce2x ratio", n2, 2*n1);
    chk(n4 >= 4*n1 - 4 && n4 <= 4*n1 + 4, "R3 ce4x ratio", n4, 4*n1);
    // R1: rx_ref toggles at another phase with cd low, lock undisturbed
    chk(held, "R1 rx_ref ignored while cd low", int'(held), 1);

    cd = 1'b1;
    @(negedge clk);
    chk(silence == 1'b1, "R9 silence after cd rise", int'(silence), 1);
    fell_at = -1; relock_at = -1; sil_p = 0;
    for (int i = 1; i <= 1200; i++) begin
      if (silence && ce1x) sil_p++;
      if (fell_at < 0 && !lock) fell_at = i;
      if (fell_at >= 0 && relock_at < 0 && lock) relock_at = i;
      @(negedge clk);
    end
    // R6
    chk(fell_at >= 0 && fell_at <= 80, "R6 lock drops on phase step", fell_at, 80);
    // R7
    chk(relock_at > 0 && relock_at <= 960, "R7 relock within 24 bit times", relock_at, 960);
    chk(sil_p == 18, "R9 silence ce1x pulses", sil_p, 18);
    chk(silence == 1'b0, "R9 silence cleared", int'(silence), 0);

    cd = 1'b0;
    n1 = 0;
    repeat (400) begin
      @(negedge clk);
      n1 += int'(ce1x);
    end
    // R5
    chk(n1 >= 8 && n1 <= 12, "R5 ce1x continuous at hand-off", n1, 10);
    repeat (1200) @(negedge clk);
    chk(lock == 1'b1, "R5 relock on local reference", int'(lock), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule